// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources plus one non-maskable input. It chooses one of them to offer to a processor core. Every source has its own settings: an enable, a 4-bit priority, the signal transitions that count as an event, and whether its pending flag clears by itself on acknowledge or waits for an explicit clear. The core answers the request line with an acknowledge pulse when it enters a handler and a return pulse when it leaves one. The controller produces a source number and a vector index; it does not fetch vectors or save state.

A run-time split value divides each priority into an upper preemption field and a lower sub-priority field. The controller holds a stack of the preemption levels of the handlers that are running. A new request is offered only when its level is strictly more urgent than the level on top of the stack. On a return the top entry is popped. If something is already eligible at that moment, the next request goes out at once with a tail-chain flag, so the core can go straight from one handler into the next.

The control state machine has four states. IDLE means no handler is running and nothing is offered. PRESENT means a request is offered from idle, or as a preemption. RUN means handlers are running and nothing is offered. CHAIN means a return has just happened and any request offered is flagged as tail-chained. The transitions are:
- IDLE_TO_PRESENT: an eligible request exists.
- RUN_TO_PRESENT: an eligible request exists.
- RUN_TO_CHAIN: a return is accepted.
- PRESENT_TO_CHAIN or CHAIN_TO_CHAIN: a return is accepted.
- PRESENT_TO_RUN or CHAIN_TO_RUN: an acknowledge is accepted.
- PRESENT or CHAIN to RUN or IDLE: the offered request loses its eligibility. The target is RUN if the stack is non-empty and IDLE if it is empty.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A configured edge on a source input sets its pending flag at the next clock edge, and irq_req rises one clock edge later. irq_id gives the source number, and irq_vec gives VEC_OFS plus that number (16 plus the number by default).
- R2: A source whose enable bit is 0 still becomes pending but is never offered. Setting the enable bit later makes the stored request appear.
- R3: Among eligible requests the smallest priority value wins. Equal values go to the lowest source number.
- R4: pre_bits gives how many upper priority bits form the preemption field. The remaining lower bits only order requests within one preemption level and never cause preemption. With pre_bits = 0 no source preempts another. With pre_bits = 4 every bit counts toward preemption.
- R5: An accepted acknowledge marks the offered source active and pushes its preemption level. Any request whose level is equal or less urgent is then held back.
- R6: While handlers run, a request whose preemption level is strictly more urgent than the top of the stack is offered. Acknowledging it nests its level on top.
- R7: A source with its hold bit at 0 loses its pending flag when it is acknowledged. A source with its hold bit at 1 stays pending until its sw_clr bit is pulsed.
- R8: src_rise selects rising edges and src_fall selects falling edges. Setting both makes either transition an event.
- R9: A rising edge on nmi_in creates a request that ignores all enables and preempts every source handler. It is reported as irq_id = NSRC and irq_vec = NMI_VEC (2 by default).
- R10: On an accepted return, if an eligible request exists, irq_req and irq_tail are both high right after that clock edge.
- R11: A return pops the top stack entry, and the blocking level of the handler underneath applies again.
- R12: After reset, and right after an acknowledge when nothing else is eligible, irq_req and irq_tail are low. A return with no handler running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Raw request inputs |
| nmi_in | input | 1 | Non-maskable request input, rising edge |
| src_en | input | NSRC | Per-source enable |
| src_prio | input | NSRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_rise | input | NSRC | Rising edge counts as event |
| src_fall | input | NSRC | Falling edge counts as event |
| src_hold | input | NSRC | 1 = pending held until software clear |
| pre_bits | input | $clog2(PRIO_W+1) | Number of preemption bits |
| sw_clr | input | NSRC | Pending clear pulses |
| core_ack | input | 1 | Core enters offered handler |
| core_ret | input | 1 | Core leaves current handler |
| irq_req | output | 1 | Request to core |
| irq_id | output | $clog2(NSRC+1) | Offered source number |
| irq_vec | output | VEC_W | Offered vector index |
| irq_tail | output | 1 | Offered request is tail-chained |

## Verification
A wrong entry in the nesting stack or a stale active flag shows at the ports as a request that is missing or extra. This appears either in the cycle after the triggering edge reaches the pending flag, or in the cycle right after the return that should pop it. The bench therefore samples irq_req, irq_id and irq_tail right after each acknowledge and each return, in scenarios that nest two or three handlers. A lost pending flag in hold mode shows on the next return as a missing tail-chained request.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_RUN     = 2'd2,
        ST_CHAIN   = 2'd3
    } nic_state_e;
endpackage

// File: rtl/nic_src_track.sv
module nic_src_track #(
    parameter int NSRC = 8,
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            nmi_in,
    input  logic [NSRC-1:0] src_rise,
    input  logic [NSRC-1:0] src_fall,
    input  logic [NSRC-1:0] src_hold,
    input  logic [NSRC-1:0] sw_clr,
    input  logic            ack_fire,
    input  logic [ID_W-1:0] ack_id,
    input  logic            ret_fire,
    input  logic [ID_W-1:0] ret_id,
    output logic [NSRC:0]   pend,
    output logic [NSRC:0]   act
);
    logic [NSRC-1:0] in_q;
    logic            nmi_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic evt;
        assign evt = (src_rise[i] & src_in[i] & ~in_q[i]) |
                     (src_fall[i] & ~src_in[i] & in_q[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[i] <= 1'b0;
                pend[i] <= 1'b0;
                act[i]  <= 1'b0;
            end else begin
                in_q[i] <= src_in[i];
                if (evt)
                    pend[i] <= 1'b1;
                else if (ack_fire && ack_id == ID_W'(i) && !src_hold[i])
                    pend[i] <= 1'b0;
                else if (sw_clr[i])
                    pend[i] <= 1'b0;
                if (ack_fire && ack_id == ID_W'(i))
                    act[i] <= 1'b1;
                else if (ret_fire && ret_id == ID_W'(i))
                    act[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q      <= 1'b0;
            pend[NSRC] <= 1'b0;
            act[NSRC]  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q)
                pend[NSRC] <= 1'b1;
            else if (ack_fire && ack_id == ID_W'(NSRC))
                pend[NSRC] <= 1'b0;
            if (ack_fire && ack_id == ID_W'(NSRC))
                act[NSRC] <= 1'b1;
            else if (ret_fire && ret_id == ID_W'(NSRC))
                act[NSRC] <= 1'b0;
        end
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 4,
    parameter int PB_W   = 3,
    parameter int KEY_W  = 5
) (
    input  logic [NSRC:0]        pend,
    input  logic [NSRC:0]        act,
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [PB_W-1:0]      pre_bits,
    input  logic [KEY_W-1:0]     thresh,
    output logic                 win_valid,
    output logic [ID_W-1:0]      win_id,
    output logic [KEY_W-1:0]     win_lvl
);
    logic [PRIO_W-1:0] hi_mask;
    logic [KEY_W-1:0]  key [NSRC+1];
    logic [KEY_W-1:0]  lvl [NSRC+1];
    logic [NSRC:0]     elig;
    logic [KEY_W-1:0]  best;

    always_comb begin
        for (int j = 0; j < PRIO_W; j++)
            hi_mask[PRIO_W-1-j] = (j < int'(pre_bits));
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_key
        assign key[i]  = {1'b0, src_prio[i*PRIO_W +: PRIO_W]} + KEY_W'(1);
        assign lvl[i]  = {1'b0, src_prio[i*PRIO_W +: PRIO_W] & hi_mask} + KEY_W'(1);
        assign elig[i] = pend[i] & ~act[i] & src_en[i] & (lvl[i] < thresh);
    end

    assign key[NSRC]  = '0;
    assign lvl[NSRC]  = '0;
    assign elig[NSRC] = pend[NSRC] & ~act[NSRC] & (lvl[NSRC] < thresh);

    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_lvl   = '1;
        best      = '1;
        for (int i = 0; i <= NSRC; i++) begin
            if (elig[i] && (!win_valid || key[i] < best)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_lvl   = lvl[i];
                best      = key[i];
            end
        end
    end
endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack #(
    parameter int DEPTH = 17,
    parameter int ID_W  = 4,
    parameter int KEY_W = 5,
    parameter int DP_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [ID_W-1:0]  push_id,
    input  logic [KEY_W-1:0] push_lvl,
    output logic [ID_W-1:0]  top_id,
    output logic [KEY_W-1:0] top_lvl,
    output logic [DP_W-1:0]  depth
);
    logic [ID_W-1:0]  id_mem  [DEPTH];
    logic [KEY_W-1:0] lvl_mem [DEPTH];
    logic [DP_W-1:0]  sp_q;
    logic [DP_W-1:0]  top_idx;

    assign top_idx = (sp_q == '0) ? '0 : sp_q - DP_W'(1);
    assign top_id  = id_mem[top_idx];
    assign top_lvl = (sp_q == '0) ? '1 : lvl_mem[top_idx];
    assign depth   = sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                id_mem[k]  <= '0;
                lvl_mem[k] <= '0;
            end
        end else if (push && sp_q < DP_W'(DEPTH)) begin
            id_mem[sp_q]  <= push_id;
            lvl_mem[sp_q] <= push_lvl;
            sp_q          <= sp_q + DP_W'(1);
        end else if (pop && sp_q != '0) begin
            sp_q <= sp_q - DP_W'(1);
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 8,
    parameter int VEC_OFS = 16,
    parameter int NMI_VEC = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               src_in,
    input  logic                          nmi_in,
    input  logic [NSRC-1:0]               src_en,
    input  logic [NSRC*PRIO_W-1:0]        src_prio,
    input  logic [NSRC-1:0]               src_rise,
    input  logic [NSRC-1:0]               src_fall,
    input  logic [NSRC-1:0]               src_hold,
    input  logic [$clog2(PRIO_W+1)-1:0]   pre_bits,
    input  logic [NSRC-1:0]               sw_clr,
    input  logic                          core_ack,
    input  logic                          core_ret,
    output logic                          irq_req,
    output logic [$clog2(NSRC+1)-1:0]     irq_id,
    output logic [VEC_W-1:0]              irq_vec,
    output logic                          irq_tail
);
    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int KEY_W = PRIO_W + 1;
    localparam int STK_D = (1 << PRIO_W) + 1;
    localparam int DP_W  = $clog2(STK_D + 1);
    localparam int PB_W  = $clog2(PRIO_W + 1);

    nic_state_e       state_q, state_d;
    logic [NSRC:0]    pend, act;
    logic             win_valid;
    logic [ID_W-1:0]  win_id;
    logic [KEY_W-1:0] win_lvl;
    logic [ID_W-1:0]  top_id;
    logic [KEY_W-1:0] top_lvl;
    logic [DP_W-1:0]  depth;
    logic             offering;
    logic             ack_fire, ret_fire;

    assign offering = (state_q == ST_PRESENT) || (state_q == ST_CHAIN);
    assign ret_fire = core_ret && (depth != '0);
    assign ack_fire = core_ack && !ret_fire && offering && win_valid;

    nic_src_track #(.NSRC(NSRC), .ID_W(ID_W)) track_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .nmi_in(nmi_in),
        .src_rise(src_rise), .src_fall(src_fall), .src_hold(src_hold),
        .sw_clr(sw_clr), .ack_fire(ack_fire), .ack_id(win_id),
        .ret_fire(ret_fire), .ret_id(top_id), .pend(pend), .act(act)
    );

    nic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .PB_W(PB_W),
                  .KEY_W(KEY_W)) arb_i (
        .pend(pend), .act(act), .src_en(src_en), .src_prio(src_prio),
        .pre_bits(pre_bits), .thresh(top_lvl), .win_valid(win_valid),
        .win_id(win_id), .win_lvl(win_lvl)
    );

    nic_nest_stack #(.DEPTH(STK_D), .ID_W(ID_W), .KEY_W(KEY_W),
                     .DP_W(DP_W)) stack_i (
        .clk(clk), .rst_n(rst_n), .push(ack_fire), .pop(ret_fire),
        .push_id(win_id), .push_lvl(win_lvl), .top_id(top_id),
        .top_lvl(top_lvl), .depth(depth)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) state_d = ST_PRESENT;
            end
            ST_RUN: begin
                if (ret_fire)       state_d = ST_CHAIN;
                else if (win_valid) state_d = ST_PRESENT;
            end
            ST_PRESENT, ST_CHAIN: begin
                if (ret_fire)        state_d = ST_CHAIN;
                else if (ack_fire)   state_d = ST_RUN;
                else if (!win_valid) state_d = (depth != '0) ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req  = offering && win_valid;
        irq_tail = (state_q == ST_CHAIN) && win_valid;
        irq_id   = win_id;
        irq_vec  = (win_id == ID_W'(NSRC)) ? VEC_W'(NMI_VEC)
                                           : VEC_W'(VEC_OFS) + VEC_W'(win_id);
    end
endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int ID_W    = 4,
    parameter int KEY_W   = 5,
    parameter int DP_W    = 5,
    parameter int STK_D   = 17,
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_tail,
    input logic [ID_W-1:0]  irq_id,
    input logic [VEC_W-1:0] irq_vec,
    input nic_state_e       state_q,
    input logic [DP_W-1:0]  depth,
    input logic [KEY_W-1:0] win_lvl,
    input logic [KEY_W-1:0] top_lvl,
    input logic             ack_fire,
    input logic             ret_fire
);
    p_tail_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tail |-> irq_req);

    p_id_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_id <= ID_W'(NSRC)));

    p_nmi_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id == ID_W'(NSRC)) |-> (irq_vec == VEC_W'(NMI_VEC)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |-> (depth < DP_W'(STK_D)));

    p_strict_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (win_lvl < top_lvl));

    p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (depth == $past(depth) + DP_W'(1)));

    p_pop_shrinks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> (depth == $past(depth) - DP_W'(1)));

    p_idle_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (depth == '0));
endmodule

bind nest_irq_ctrl nic_checker #(
    .NSRC(NSRC), .ID_W(ID_W), .KEY_W(KEY_W), .DP_W(DP_W),
    .STK_D(STK_D), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_tail(irq_tail),
    .irq_id(irq_id), .irq_vec(irq_vec), .state_q(state_q), .depth(depth),
    .win_lvl(win_lvl), .top_lvl(top_lvl), .ack_fire(ack_fire),
    .ret_fire(ret_fire)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module nest_irq_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int PW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_in = '0;
    logic              nmi_in = 1'b0;
    logic [NSRC-1:0]   src_en = '1;
    logic [NSRC*PW-1:0] src_prio = '1;
    logic [NSRC-1:0]   src_rise = '1;
    logic [NSRC-1:0]   src_fall = '0;
    logic [NSRC-1:0]   src_hold = '0;
    logic [2:0]        pre_bits = 3'd2;
    logic [NSRC-1:0]   sw_clr = '0;
    logic              core_ack = 1'b0;
    logic              core_ret = 1'b0;
    logic              irq_req;
    logic [3:0]        irq_id;
    logic [7:0]        irq_vec;
    logic              irq_tail;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.NSRC(NSRC), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .nmi_in(nmi_in),
        .src_en(src_en), .src_prio(src_prio), .src_rise(src_rise),
        .src_fall(src_fall), .src_hold(src_hold), .pre_bits(pre_bits),
        .sw_clr(sw_clr), .core_ack(core_ack), .core_ret(core_ret),
        .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec),
        .irq_tail(irq_tail)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_prio(input int i, input int p);
        src_prio[i*PW +: PW] = PW'(p);
    endtask

    task automatic raise(input logic [NSRC-1:0] m);
        @(negedge clk) src_in = src_in | m;
        @(negedge clk) src_in = src_in & ~m;
    endtask

    task automatic do_ack();
        @(negedge clk) core_ack = 1'b1;
        @(negedge clk) core_ack = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk) core_ret = 1'b1;
        @(negedge clk) core_ret = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 12; k++) begin
            wait_cyc(3);
            if (irq_req) begin
                do_ack();
                do_ret();
            end
        end
        @(negedge clk) sw_clr = '1;
        @(negedge clk) sw_clr = '0;
    endtask

    task automatic t_reset();
        check("R12 reset irq_req", irq_req, 0);
        check("R12 reset irq_tail", irq_tail, 0);
        do_ret();
        wait_cyc(2);
        check("R12 stray return ignored", irq_req, 0);
    endtask

    task automatic t_latency();
        set_prio(0, 4);
        @(negedge clk) src_in[0] = 1'b1;
        @(negedge clk);
        check("R1 no request one edge after input", irq_req, 0);
        @(negedge clk);
        check("R1 request two edges after input", irq_req, 1);
        check("R1 id", irq_id, 0);
        check("R1 vector", irq_vec, 16);
        src_in[0] = 1'b0;
        do_ack();
        check("R12 request drops after ack", irq_req, 0);
        check("R7 pulse mode no rerequest", irq_tail, 0);
        do_ret();
        check("R7 pulse pending cleared on ack", irq_req, 0);
        set_prio(0, 15);
    endtask

    task automatic t_order();
        set_prio(3, 8); set_prio(5, 4);
        raise(8'b0010_1000);
        wait_cyc(3);
        check("R3 lower value wins", irq_id, 5);
        drain();
        set_prio(2, 8); set_prio(6, 8);
        raise(8'b0100_0100);
        wait_cyc(3);
        check("R3 tie goes to lower index", irq_id, 2);
        check("R3 vector of winner", irq_vec, 18);
        drain();
        set_prio(1, 9); set_prio(4, 8);
        raise(8'b0001_0010);
        wait_cyc(3);
        check("R4 sub-priority orders within level", irq_id, 4);
        drain();
        src_prio = '1;
    endtask

    task automatic t_mask();
        src_en[6] = 1'b0;
        raise(8'b0100_0000);
        wait_cyc(4);
        check("R2 masked source not offered", irq_req, 0);
        src_en[6] = 1'b1;
        wait_cyc(2);
        check("R2 stored request appears on enable", irq_req, 1);
        check("R2 id after enable", irq_id, 6);
        drain();
    endtask

    task automatic t_nest();
        set_prio(1, 8); set_prio(2, 9); set_prio(3, 4);
        raise(8'b0000_0010);
        wait_cyc(3);
        do_ack();
        raise(8'b0000_0100);
        wait_cyc(4);
        check("R5 same level blocked", irq_req, 0);
        raise(8'b0000_1000);
        wait_cyc(3);
        check("R6 more urgent level preempts", irq_req, 1);
        check("R6 preempting id", irq_id, 3);
        check("R6 preemption not tail-chained", irq_tail, 0);
        do_ack();
        check("R5 no request after nested ack", irq_req, 0);
        do_ret();
        check("R11 outer level blocks again after pop", irq_req, 0);
        do_ret();
        check("R10 tail-chain request on return", irq_req, 1);
        check("R10 tail flag", irq_tail, 1);
        check("R10 chained id", irq_id, 2);
        do_ack();
        do_ret();
        check("R11 all popped, quiet", irq_req, 0);
        src_prio = '1;
    endtask

    task automatic t_split();
        set_prio(1, 9); set_prio(4, 8);
        raise(8'b0000_0010);
        wait_cyc(3);
        do_ack();
        raise(8'b0001_0000);
        wait_cyc(4);
        check("R4 sub-priority does not preempt", irq_req, 0);
        do_ret();
        check("R4 waiting request chains on return", irq_id, 4);
        drain();
        pre_bits = 3'd0;
        set_prio(2, 15); set_prio(1, 0);
        raise(8'b0000_0100);
        wait_cyc(3);
        do_ack();
        raise(8'b0000_0010);
        wait_cyc(4);
        check("R4 zero preemption bits never preempt", irq_req, 0);
        do_ret();
        drain();
        pre_bits = 3'd4;
        set_prio(1, 14);
        raise(8'b0000_0100);
        wait_cyc(3);
        do_ack();
        raise(8'b0000_0010);
        wait_cyc(3);
        check("R4 four preemption bits preempt", irq_req, 1);
        check("R4 preempting id", irq_id, 1);
        do_ack();
        do_ret();
        do_ret();
        drain();
        pre_bits = 3'd2;
        src_prio = '1;
    endtask

    task automatic t_latched();
        src_hold[4] = 1'b1;
        raise(8'b0001_0000);
        wait_cyc(3);
        do_ack();
        check("R7 held source not reoffered while active", irq_req, 0);
        do_ret();
        check("R7 held pending survives ack", irq_req, 1);
        check("R7 held id chained", irq_id, 4);
        do_ack();
        @(negedge clk) sw_clr[4] = 1'b1;
        @(negedge clk) sw_clr[4] = 1'b0;
        do_ret();
        check("R7 software clear removes pending", irq_req, 0);
        src_hold[4] = 1'b0;
    endtask

    task automatic t_edges();
        src_rise[5] = 1'b0; src_fall[5] = 1'b1;
        @(negedge clk) src_in[5] = 1'b1;
        wait_cyc(4);
        check("R8 rise ignored in fall mode", irq_req, 0);
        src_in[5] = 1'b0;
        wait_cyc(3);
        check("R8 fall triggers", irq_req, 1);
        drain();
        src_rise[5] = 1'b1;
        @(negedge clk) src_in[5] = 1'b1;
        wait_cyc(3);
        check("R8 both mode rise triggers", irq_req, 1);
        do_ack(); do_ret();
        @(negedge clk) src_in[5] = 1'b0;
        wait_cyc(3);
        check("R8 both mode fall triggers", irq_req, 1);
        drain();
        src_fall[5] = 1'b0;
    endtask

    task automatic t_nmi();
        set_prio(0, 0);
        raise(8'b0000_0001);
        wait_cyc(3);
        do_ack();
        src_en = '0;
        @(negedge clk) nmi_in = 1'b1;
        wait_cyc(3);
        check("R9 nmi preempts most urgent source", irq_req, 1);
        check("R9 nmi id", irq_id, NSRC);
        check("R9 nmi vector", irq_vec, 2);
        nmi_in = 1'b0;
        do_ack();
        check("R9 nmi cleared on ack", irq_req, 0);
        do_ret();
        do_ret();
        check("R9 all returned", irq_req, 0);
        src_en = '1;
        src_prio = '1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_latency();
        t_order();
        t_mask();
        t_nest();
        t_split();
        t_latched();
        t_edges();
        t_nmi();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule